// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control sequencer that enters and leaves interrupt service routines in a small 8-bit CPU. The core raises `fetch_req` each time it reaches an instruction-fetch boundary. At that moment, and only then, the sequencer looks at the interrupt request line and at the enable flag held in the status word. It grants the request if the flag is set. When it grants, it pulses an acknowledge, latches the requesting device's number, and replaces the normal fetch with a five-cycle virtual instruction. That instruction saves the program counter and the status word on a downward-growing stack. It then loads both registers from the device's two-byte vector.

The core can also start the same five-cycle entry for a decoded software-interrupt opcode, passing the number carried in the instruction. It can start a two-cycle return sequence that pops the status word and the program counter back off the stack. The sequencer drives the memory strobes, the address and write data, and load strobes with next values for the stack pointer, program counter and status word. The core owns those registers and feeds their current values back in.

Top module: `intr_entry_seq`

## Requirements
- R1: Out of reset the sequencer is idle: `busy`, `iack`, `fetch_go`, both memory strobes and all three load strobes are low while no request is applied.
- R2: The request line is sampled only in an idle cycle with `fetch_req` high. A request applied without `fetch_req`, or while `busy` is high, causes no acknowledge and does not change the sequence being run.
- R3: A hardware request is granted only when bit 7 of `ps_in` is 1. In the grant cycle `iack` is high for exactly that one cycle and `irq_dev` is latched. An idle cycle with `fetch_req` high that grants nothing, and has no return or software request, raises `fetch_go` instead.
- R4: The first entry cycle, one cycle after acceptance, loads SP with `sp_in`-1 and touches no memory.
- R5: The second entry cycle writes `pc_in` to address `sp_in` and loads SP with `sp_in`-1.
- R6: The third entry cycle writes `ps_in` to address `sp_in` and loads nothing.
- R7: The fourth entry cycle reads address 0xF0+2R into PC, and the fifth reads address 0xF1+2R into PS. R is the 3-bit number latched at acceptance.
- R8: A software-interrupt request runs the same five cycles, with R taken from `swi_dev`.
- R9: A return request reads PS from address `sp_in` in its first cycle. In its second cycle it reads PC from `sp_in`+1 and loads SP with `sp_in`+2.
- R10: Among requests present in the same idle cycle, return wins over software interrupt, and software interrupt wins over the fetch-boundary path.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Core is at an instruction-fetch boundary |
| irq | input | 1 | Hardware interrupt request |
| irq_dev | input | 3 | Number of the requesting device |
| iack | output | 1 | One-cycle grant acknowledge |
| swi_req | input | 1 | Core decoded a software-interrupt opcode |
| swi_dev | input | 3 | Vector number carried by that opcode |
| rti_req | input | 1 | Core decoded a return-from-interrupt opcode |
| pc_in | input | 8 | Current program counter |
| ps_in | input | 8 | Current status word (bit 7 enables interrupts) |
| sp_in | input | 8 | Current stack pointer (last written byte) |
| fetch_go | output | 1 | Normal fetch may proceed this cycle |
| busy | output | 1 | An entry or return sequence is running |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| sp_ld | output | 1 | Load SP with `sp_nxt` |
| sp_nxt | output | 8 | Next stack pointer value |
| pc_ld | output | 1 | Load PC with `pc_nxt` |
| pc_nxt | output | 8 | Next program counter value |
| ps_ld | output | 1 | Load PS with `ps_nxt` |
| ps_nxt | output | 8 | Next status word value |

## Verification
The bench builds the block with its default widths: an 8-bit word, a 3-bit device number, the enable flag at bit 7 and a vector base of 0xF0. With these, every vector pair from 0xF0 up to 0xFF can be reached, including device 0 and device 7. Vector status words are chosen so that odd devices leave interrupts enabled and even devices clear them. This exercises both a nested grant from inside a handler and a refused request after entry. Stacked entries followed by two returns check that the pops exactly undo the pushes.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    // Sequencer phases: idle, five entry cycles, two return cycles.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PUSH_DEC = 3'd1,
        ST_PUSH_PC  = 3'd2,
        ST_PUSH_PS  = 3'd3,
        ST_VEC_PC   = 3'd4,
        ST_VEC_PS   = 3'd5,
        ST_RET_PS   = 3'd6,
        ST_RET_PC   = 3'd7
    } seq_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } mem_strobe_t;

    typedef struct packed {
        logic sp;
        logic pc;
        logic ps;
    } reg_load_t;

    function automatic logic is_entry(input seq_state_e s);
        return (s == ST_PUSH_DEC) || (s == ST_PUSH_PC) || (s == ST_PUSH_PS) ||
               (s == ST_VEC_PC)   || (s == ST_VEC_PS);
    endfunction

endpackage

// File: rtl/intr_arb.sv
module intr_arb #(
    parameter int DEV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle,
    input  logic             fetch_req,
    input  logic             irq,
    input  logic [DEV_W-1:0] irq_dev,
    input  logic             ie_flag,
    input  logic             swi_req,
    input  logic [DEV_W-1:0] swi_dev,
    input  logic             rti_req,
    output logic             start_entry,
    output logic             start_ret,
    output logic             iack,
    output logic             fetch_go,
    output logic [DEV_W-1:0] dev_q
);
    logic open_slot;
    logic take_rti;
    logic take_swi;
    logic take_irq;

    assign open_slot = idle && !rst;
    assign take_rti  = open_slot && rti_req;
    assign take_swi  = open_slot && !rti_req && swi_req;
    assign take_irq  = open_slot && !rti_req && !swi_req && fetch_req && irq && ie_flag;

    assign start_ret   = take_rti;
    assign start_entry = take_swi || take_irq;
    assign iack        = take_irq;
    assign fetch_go    = open_slot && !rti_req && !swi_req && fetch_req && !take_irq;

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_q <= '0;
        end else if (take_irq) begin
            dev_q <= irq_dev;
        end else if (take_swi) begin
            dev_q <= swi_dev;
        end
    end

    // R3
    iack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        iack |=> !iack);

    // R3
    dev_latch_chk: assert property (@(posedge clk) disable iff (rst)
        iack |=> dev_q == $past(irq_dev));

endmodule

// File: rtl/intr_fsm.sv
module intr_fsm
    import intr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_entry,
    input  logic       start_ret,
    output seq_state_e state,
    output logic       idle
);
    seq_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_ret)        state_nx = ST_RET_PS;
                else if (start_entry) state_nx = ST_PUSH_DEC;
            end
            ST_PUSH_DEC: state_nx = ST_PUSH_PC;
            ST_PUSH_PC:  state_nx = ST_PUSH_PS;
            ST_PUSH_PS:  state_nx = ST_VEC_PC;
            ST_VEC_PC:   state_nx = ST_VEC_PS;
            ST_VEC_PS:   state_nx = ST_IDLE;
            ST_RET_PS:   state_nx = ST_RET_PC;
            ST_RET_PC:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign idle = (state == ST_IDLE);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        is_entry(state) && state != ST_VEC_PS |=> !idle);

endmodule

// File: rtl/intr_bus.sv
module intr_bus
    import intr_seq_pkg::*;
#(
    parameter int W        = 8,
    parameter int DEV_W    = 3,
    parameter int VEC_BASE = 'hF0
) (
    input  seq_state_e       state,
    input  logic [DEV_W-1:0] dev_q,
    input  logic [W-1:0]     pc_in,
    input  logic [W-1:0]     ps_in,
    input  logic [W-1:0]     sp_in,
    input  logic [W-1:0]     mem_rdata,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [W-1:0]     mem_addr,
    output logic [W-1:0]     mem_wdata,
    output logic             sp_ld,
    output logic [W-1:0]     sp_nxt,
    output logic             pc_ld,
    output logic [W-1:0]     pc_nxt,
    output logic             ps_ld,
    output logic [W-1:0]     ps_nxt
);
    localparam logic [W-1:0] BASE = W'(VEC_BASE);

    mem_strobe_t strb;
    reg_load_t   lds;
    logic [W-1:0] vec_even;

    assign vec_even = BASE + W'({dev_q, 1'b0});

    always_comb begin
        strb      = '0;
        lds       = '0;
        mem_addr  = '0;
        mem_wdata = '0;
        sp_nxt    = sp_in;
        pc_nxt    = pc_in;
        ps_nxt    = ps_in;
        unique case (state)
            ST_PUSH_DEC: begin
                lds.sp = 1'b1;
                sp_nxt = sp_in - W'(1);
            end
            ST_PUSH_PC: begin
                strb.wr   = 1'b1;
                mem_addr  = sp_in;
                mem_wdata = pc_in;
                lds.sp    = 1'b1;
                sp_nxt    = sp_in - W'(1);
            end
            ST_PUSH_PS: begin
                strb.wr   = 1'b1;
                mem_addr  = sp_in;
                mem_wdata = ps_in;
            end
            ST_VEC_PC: begin
                strb.rd  = 1'b1;
                mem_addr = vec_even;
                lds.pc   = 1'b1;
                pc_nxt   = mem_rdata;
            end
            ST_VEC_PS: begin
                strb.rd  = 1'b1;
                mem_addr = vec_even + W'(1);
                lds.ps   = 1'b1;
                ps_nxt   = mem_rdata;
            end
            ST_RET_PS: begin
                strb.rd  = 1'b1;
                mem_addr = sp_in;
                lds.ps   = 1'b1;
                ps_nxt   = mem_rdata;
            end
            ST_RET_PC: begin
                strb.rd  = 1'b1;
                mem_addr = sp_in + W'(1);
                lds.pc   = 1'b1;
                pc_nxt   = mem_rdata;
                lds.sp   = 1'b1;
                sp_nxt   = sp_in + W'(2);
            end
            default: ;
        endcase
    end

    assign mem_rd = strb.rd;
    assign mem_wr = strb.wr;
    assign sp_ld  = lds.sp;
    assign pc_ld  = lds.pc;
    assign ps_ld  = lds.ps;

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import intr_seq_pkg::*;
#(
    parameter int W        = 8,
    parameter int DEV_W    = 3,
    parameter int IE_BIT   = 7,
    parameter int VEC_BASE = 'hF0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_req,
    input  logic             irq,
    input  logic [DEV_W-1:0] irq_dev,
    output logic             iack,
    input  logic             swi_req,
    input  logic [DEV_W-1:0] swi_dev,
    input  logic             rti_req,
    input  logic [W-1:0]     pc_in,
    input  logic [W-1:0]     ps_in,
    input  logic [W-1:0]     sp_in,
    output logic             fetch_go,
    output logic             busy,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [W-1:0]     mem_addr,
    output logic [W-1:0]     mem_wdata,
    input  logic [W-1:0]     mem_rdata,
    output logic             sp_ld,
    output logic [W-1:0]     sp_nxt,
    output logic             pc_ld,
    output logic [W-1:0]     pc_nxt,
    output logic             ps_ld,
    output logic [W-1:0]     ps_nxt
);
    seq_state_e       state;
    logic             idle;
    logic             start_entry;
    logic             start_ret;
    logic [DEV_W-1:0] dev_q;

    intr_arb #(.DEV_W(DEV_W)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .idle        (idle),
        .fetch_req   (fetch_req),
        .irq         (irq),
        .irq_dev     (irq_dev),
        .ie_flag     (ps_in[IE_BIT]),
        .swi_req     (swi_req),
        .swi_dev     (swi_dev),
        .rti_req     (rti_req),
        .start_entry (start_entry),
        .start_ret   (start_ret),
        .iack        (iack),
        .fetch_go    (fetch_go),
        .dev_q       (dev_q)
    );

    intr_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_entry (start_entry),
        .start_ret   (start_ret),
        .state       (state),
        .idle        (idle)
    );

    intr_bus #(.W(W), .DEV_W(DEV_W), .VEC_BASE(VEC_BASE)) u_bus (
        .state     (state),
        .dev_q     (dev_q),
        .pc_in     (pc_in),
        .ps_in     (ps_in),
        .sp_in     (sp_in),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sp_ld     (sp_ld),
        .sp_nxt    (sp_nxt),
        .pc_ld     (pc_ld),
        .pc_nxt    (pc_nxt),
        .ps_ld     (ps_ld),
        .ps_nxt    (ps_nxt)
    );

    assign busy = !idle;

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R3
    iack_gate_chk: assert property (@(posedge clk) disable iff (rst)
        iack |-> irq && fetch_req && ps_in[IE_BIT]);

    // R4
    entry_first_chk: assert property (@(posedge clk) disable iff (rst)
        iack |=> sp_ld && !mem_wr && !mem_rd);

    // R2
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !iack && !fetch_go);

    // R9
    ret_order_chk: assert property (@(posedge clk) disable iff (rst)
        pc_ld && sp_ld |-> $past(ps_ld) && mem_rd);

    // R7
    vec_read_chk: assert property (@(posedge clk) disable iff (rst)
        pc_ld && !sp_ld |-> mem_rd && !mem_addr[0]);

endmodule

// File: tb/intr_entry_seq_bench.sv
module intr_entry_seq_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fetch_req = 1'b0, irq = 1'b0, swi_req = 1'b0, rti_req = 1'b0;
    logic [2:0] irq_dev = '0, swi_dev = '0;
    logic [7:0] m_pc, m_ps, m_sp;
    logic [7:0] mem [256];
    logic       iack, fetch_go, busy, mem_rd, mem_wr, sp_ld, pc_ld, ps_ld;
    logic [7:0] mem_addr, mem_wdata, mem_rdata, sp_nxt, pc_nxt, ps_nxt;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    int q[$];
    logic [2:0] m_r;
    bit m_sw;

    always #(CLK_P/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    intr_entry_seq u_intr_entry_seq (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .irq(irq), .irq_dev(irq_dev),
        .iack(iack), .swi_req(swi_req), .swi_dev(swi_dev), .rti_req(rti_req),
        .pc_in(m_pc), .ps_in(m_ps), .sp_in(m_sp), .fetch_go(fetch_go), .busy(busy),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .sp_ld(sp_ld), .sp_nxt(sp_nxt), .pc_ld(pc_ld),
        .pc_nxt(pc_nxt), .ps_ld(ps_ld), .ps_nxt(ps_nxt)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: evaluated every cycle away from the active edge.
    always @(negedge clk) begin
        logic e_iack, e_fg, e_busy, e_rd, e_wr, e_spl, e_pcl, e_psl;
        logic [7:0] e_addr, e_wd, e_sp, e_pc, e_ps;
        string tag;
        int op;
        e_iack = 0; e_fg = 0; e_busy = 0; e_rd = 0; e_wr = 0;
        e_spl = 0; e_pcl = 0; e_psl = 0;
        e_addr = 0; e_wd = 0; e_sp = 0; e_pc = 0; e_ps = 0;
        tag = "R3";
        op = 0;
        if (rst) begin
            q.delete();
            tag = "R1";
        end else if (q.size() == 0) begin
            if (rti_req) begin
                q.push_back(6); q.push_back(7); tag = "R10";
            end else if (swi_req) begin
                m_r = swi_dev; m_sw = 1;
                for (int k = 1; k <= 5; k++) q.push_back(k);
                tag = "R10";
            end else if (fetch_req && irq && m_ps[7]) begin
                e_iack = 1; m_r = irq_dev; m_sw = 0;
                for (int k = 1; k <= 5; k++) q.push_back(k);
            end else if (fetch_req) begin
                e_fg = 1;
            end
        end else begin
            e_busy = 1;
            op = q.pop_front();
            case (op)
                1: begin tag = "R4"; e_spl = 1; e_sp = m_sp - 8'd1; end
                2: begin tag = "R5"; e_wr = 1; e_addr = m_sp; e_wd = m_pc;
                         e_spl = 1; e_sp = m_sp - 8'd1; end
                3: begin tag = "R6"; e_wr = 1; e_addr = m_sp; e_wd = m_ps; end
                4: begin tag = "R7"; e_rd = 1; e_addr = 8'hF0 + {4'd0, m_r, 1'b0};
                         e_pcl = 1; e_pc = mem[e_addr]; end
                5: begin tag = "R7"; e_rd = 1; e_addr = 8'hF1 + {4'd0, m_r, 1'b0};
                         e_psl = 1; e_ps = mem[e_addr]; end
                6: begin tag = "R9"; e_rd = 1; e_addr = m_sp; e_psl = 1; e_ps = mem[m_sp]; end
                default: begin tag = "R9"; e_rd = 1; e_addr = m_sp + 8'd1;
                         e_pcl = 1; e_pc = mem[e_addr]; e_spl = 1; e_sp = m_sp + 8'd2; end
            endcase
            if (m_sw && op <= 5) tag = "R8";
        end

        chk(tag, "iack", {7'd0, iack}, {7'd0, e_iack});
        chk(tag, "fetch_go", {7'd0, fetch_go}, {7'd0, e_fg});
        chk(tag, "busy", {7'd0, busy}, {7'd0, e_busy});
        chk(tag, "mem_rd", {7'd0, mem_rd}, {7'd0, e_rd});
        chk(tag, "mem_wr", {7'd0, mem_wr}, {7'd0, e_wr});
        chk("R11", "rd&wr", {7'd0, mem_rd & mem_wr}, 8'd0);
        chk(tag, "sp_ld", {7'd0, sp_ld}, {7'd0, e_spl});
        chk(tag, "pc_ld", {7'd0, pc_ld}, {7'd0, e_pcl});
        chk(tag, "ps_ld", {7'd0, ps_ld}, {7'd0, e_psl});
        if (e_rd || e_wr) chk(tag, "mem_addr", mem_addr, e_addr);
        if (e_wr)  chk(tag, "mem_wdata", mem_wdata, e_wd);
        if (e_spl) chk(tag, "sp_nxt", sp_nxt, e_sp);
        if (e_pcl) chk(tag, "pc_nxt", pc_nxt, e_pc);
        if (e_psl) chk(tag, "ps_nxt", ps_nxt, e_ps);

        // Core register and memory effects, taken from the model only.
        if (e_wr)  mem[e_addr] = e_wd;
        if (e_spl) m_sp = e_sp;
        if (e_pcl) m_pc = e_pc;
        if (e_psl) m_ps = e_ps;
        if (e_fg)  m_pc = m_pc + 8'd1;
    end

    task automatic drive(input logic f, input logic i, input logic [2:0] d,
                         input logic s, input logic [2:0] sd, input logic r);
        @(posedge clk); #1;
        fetch_req = f; irq = i; irq_dev = d; swi_req = s; swi_dev = sd; rti_req = r;
    endtask

    task automatic quiet(input int n);
        for (int k = 0; k < n; k++) drive(0, 0, 3'd0, 0, 3'd0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        mismatched++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'(a ^ 8'h5A);
        for (int r = 0; r < 8; r++) begin
            mem[8'hF0 + 2*r] = 8'(8'h10 + 8*r);
            mem[8'hF1 + 2*r] = (r % 2 == 1) ? 8'(8'h80 | r) : 8'(r);
        end
        m_pc = 8'h40; m_ps = 8'h80; m_sp = 8'hE0; m_r = 0; m_sw = 0;
        // R1: reset state observed by the model during reset
        quiet(3);
        @(posedge clk); #1; rst = 0;
        quiet(1);
        // R3: plain fetches
        drive(1, 0, 3'd0, 0, 3'd0, 0);
        drive(1, 0, 3'd0, 0, 3'd0, 0);
        // R2: request without fetch boundary
        drive(0, 1, 3'd5, 0, 3'd0, 0);
        drive(0, 1, 3'd5, 0, 3'd0, 0);
        // R3: grant device 5, then R2: requests held during busy are ignored
        drive(1, 1, 3'd5, 0, 3'd0, 0);
        for (int k = 0; k < 5; k++) drive(1, 1, 3'd1, 0, 3'd0, 0);
        // nested grant of device 2 (vector 5 left interrupts enabled)
        drive(1, 1, 3'd2, 0, 3'd0, 0);
        quiet(5);
        // R3: vector 2 cleared the enable flag, so device 6 is refused
        drive(1, 1, 3'd6, 0, 3'd0, 0);
        drive(1, 1, 3'd6, 0, 3'd0, 0);
        // R9: two returns undo both entries
        drive(0, 0, 3'd0, 0, 3'd0, 1);
        quiet(3);
        drive(0, 0, 3'd0, 0, 3'd0, 1);
        quiet(3);
        // R8 / R10: software interrupt wins over fetch and irq
        drive(1, 1, 3'd3, 1, 3'd7, 0);
        quiet(6);
        // R10: return wins over software interrupt and fetch
        drive(1, 1, 3'd3, 1, 3'd4, 1);
        quiet(3);
        // R8: software interrupt 0, which clears the enable flag
        drive(0, 0, 3'd0, 1, 3'd0, 0);
        quiet(6);
        // R3: refused while disabled; fetch proceeds
        drive(1, 1, 3'd7, 0, 3'd0, 0);
        drive(0, 0, 3'd0, 0, 3'd0, 1);
        quiet(3);
        // R7: grant device 0 after the enable flag is restored
        drive(1, 1, 3'd0, 0, 3'd0, 0);
        quiet(7);
        finish_run();
    end

endmodule